// File: doc/BRIEF.md
# Lane Alignment Sequence Generator

This block produces the octet stream of a single serial lane from the moment a receiver asks for link synchronization until payload flows. While the receiver holds its sync request, the lane carries a steady stream of comma characters. Once the request is released, the block waits for the next multiframe boundary. It then either plays a four-multiframe alignment pattern or goes straight to payload. The second multiframe of that pattern carries a 14-octet record describing the link setup, closed by a checksum.

The link setup fields are sampled into shadow registers only while the sync request is high, so the multiframe length stays fixed while the lane runs. The multiframe length is K frames of F octets. An internal octet counter marks the multiframe boundaries. A registered flag reports settings whose frames-per-multiframe value is illegal. A second output tells a downstream scrambler when it may be enabled. It is high only on payload octets, and only when scrambling is selected.

Top module: `lane_ila_seq`

## Requirements
- R1: After reset the outputs are the comma 0xBC with the control flag set, with scr_on and cfg_err low. The shadow setup then holds K = 32 (frms_m1 = 31), F = 1, scrambling on and mode "once" until a setup is loaded.
- R2: While sync_req is high, every octet is the comma 0xBC with the control flag set, and the setup inputs are copied into the shadow registers. Raising sync_req while the pattern or payload is running gives a comma octet two cycles later.
- R3: After sync_req falls, the next octet stream starts at the next multiframe boundary. The pattern spans four multiframes of K×F octets each. Each multiframe starts with 0x1C and ends with 0x7C, both with the control flag set.
- R4: In the second multiframe of the pattern, octet 1 is 0x9C with the control flag set and octets 2 to 15 carry the record. Every other octet of the pattern equals its index within the multiframe (low 8 bits), with the control flag clear.
- R5: The record octets in order are:
  - 0: dev_id
  - 1: {0000, bank_id}
  - 2: {000, lane_id}
  - 3: {scr, 00, lanes_m1}
  - 4: octs_m1
  - 5: {000, frms_m1}
  - 6: convs_m1
  - 7: {ctl_bits, 0, res_m1}
  - 8: {subcls, smpw_m1}
  - 9: {ver, spc_m1}
  - 10: {hdens, 00, ctl_words}
  - 11 and 12: zero
  - 13: checksum
- R6: The checksum is the modulo-256 sum of the sixteen unpacked fields. These are dev_id, bank_id, lane_id, scr, lanes_m1, octs_m1, frms_m1, convs_m1, ctl_bits, res_m1, smpw_m1, subcls, spc_m1, ver, ctl_words and hdens. They are summed as values, not as the packed octets.
- R7: seq_mode 00 skips the pattern, so payload starts at the boundary. Modes 01 and 11 play the pattern once, then go to payload. Mode 10 replays the four-multiframe pattern forever and never reaches payload.
- R8: scr_on is high only on payload octets, and only when the shadow scrambling setting is 1. It is low on every comma and pattern octet.
- R9: Payload octets carry pl_octet with the control flag clear.
- R10: cfg_err is high when K (frms_m1 + 1) is not a multiple of 4, or when K×F lies outside 17 to 1024. It follows a new setup two cycles after the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Octet clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | 1 | Receiver sync request; high forces commas and loads the setup |
| seq_mode | input | 2 | Pattern mode: 00 off, 01 once, 10 repeat, 11 once |
| scr_cfg | input | 1 | Scrambling selection |
| dev_id | input | 8 | Device identifier |
| bank_id | input | 4 | Bank identifier |
| lane_id | input | 5 | Lane identifier |
| lanes_m1 | input | 5 | Lanes per link minus one |
| octs_m1 | input | 8 | Octets per frame minus one |
| frms_m1 | input | 5 | Frames per multiframe minus one |
| convs_m1 | input | 8 | Converters minus one |
| res_m1 | input | 5 | Converter resolution minus one |
| smpw_m1 | input | 5 | Bits per sample minus one |
| ctl_bits | input | 2 | Control bits per sample |
| ctl_words | input | 5 | Control words per frame |
| spc_m1 | input | 5 | Samples per converter per frame minus one |
| hdens | input | 1 | High-density flag |
| subcls | input | 3 | Device subclass |
| ver | input | 3 | Protocol version |
| pl_octet | input | 8 | Payload octet from the frame datapath |
| tx_octet | output | 8 | Lane octet |
| tx_ctrl | output | 1 | Octet is a control character |
| scr_on | output | 1 | Scrambler may run on this octet |
| cfg_err | output | 1 | Frames-per-multiframe setting is illegal |

## Verification
The pattern is exercised with a setup whose control bits, subclass, version and high-density flag are nonzero, so a checksum taken over packed octets differs from the field sum. A second setup turns scrambling off, which changes the record, the checksum and scr_on. The default frames-per-multiframe value is observed with different live inputs and no load, to show the shadow defaults are in use. The three modes are compared on the same setup: once gives payload after four multiframes, off gives payload at the first boundary, and repeat gives eight multiframes with the record in the second and sixth. Separate cases cover an abort in the middle of the pattern, and legal and illegal K×F settings at both sides of the limits.

// File: rtl/lane_ila_pkg.sv
package lane_ila_pkg;

  localparam int OCT_W   = 8;
  localparam int REC_LEN = 14;
  localparam int KF_W    = 13;   // frames(32) x octets(256) - 1 fits
  localparam int NFLD    = 16;

  localparam logic [OCT_W-1:0] CH_COMMA = 8'hBC;
  localparam logic [OCT_W-1:0] CH_START = 8'h1C;
  localparam logic [OCT_W-1:0] CH_ALIGN = 8'h7C;
  localparam logic [OCT_W-1:0] CH_CFG   = 8'h9C;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_LOOP = 2'b10,
    MODE_RSVD = 2'b11
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_SYNC  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_DATA  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [7:0] dev_id;
    logic [3:0] bank_id;
    logic [4:0] lane_id;
    logic       scr;
    logic [4:0] lanes_m1;
    logic [7:0] octs_m1;
    logic [4:0] frms_m1;
    logic [7:0] convs_m1;
    logic [4:0] res_m1;
    logic [4:0] smpw_m1;
    logic [1:0] ctl_bits;
    logic [4:0] ctl_words;
    logic [4:0] spc_m1;
    logic       hdens;
    logic [2:0] subcls;
    logic [2:0] ver;
    seq_mode_e  mode;
  } link_cfg_t;

endpackage

// File: rtl/ila_cfg_shadow.sv
module ila_cfg_shadow
  import lane_ila_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  link_cfg_t cfg_in,
  output link_cfg_t cfg_q
);

  link_cfg_t cfg_rst;

  always_comb begin
    cfg_rst         = '0;
    cfg_rst.frms_m1 = 5'd31;      // K = 32 after reset
    cfg_rst.scr     = 1'b1;       // scrambling selected after reset
    cfg_rst.mode    = MODE_ONCE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= cfg_rst;
    end else if (load) begin
      cfg_q <= cfg_in;
    end
  end

endmodule

// File: rtl/ila_cfg_check.sv
module ila_cfg_check
  import lane_ila_pkg::*;
#(
  parameter int MIN_OCTS = 17,
  parameter int MAX_OCTS = 1024,
  parameter int K_STEP   = 4
) (
  input  link_cfg_t        cfg,
  output logic [KF_W-1:0]  kf_m1,
  output logic             bad
);

  localparam int PW = KF_W + 1;
  localparam int KS_W = $clog2(K_STEP);

  logic [PW-1:0] k_val;
  logic [PW-1:0] f_val;
  logic [PW-1:0] kf;
  logic          k_misaligned;

  always_comb begin
    k_val = PW'(cfg.frms_m1) + PW'(1);
    f_val = PW'(cfg.octs_m1) + PW'(1);
    kf    = k_val * f_val;
    kf_m1 = KF_W'(kf - PW'(1));
    k_misaligned = (k_val[KS_W-1:0] != '0);
    bad   = k_misaligned || (kf < PW'(MIN_OCTS)) || (kf > PW'(MAX_OCTS));
  end

endmodule

// File: rtl/ila_cfg_record.sv
module ila_cfg_record
  import lane_ila_pkg::*;
(
  input  link_cfg_t        cfg,
  input  logic [3:0]       sel,
  output logic [OCT_W-1:0] rec_oct
);

  logic [OCT_W-1:0] fld [NFLD];
  logic [OCT_W-1:0] fsum;
  logic [OCT_W-1:0] rec [REC_LEN];

  // Unpacked fields, each zero-extended, for the modulo-256 sum
  always_comb begin
    fld[0]  = cfg.dev_id;
    fld[1]  = OCT_W'(cfg.bank_id);
    fld[2]  = OCT_W'(cfg.lane_id);
    fld[3]  = OCT_W'(cfg.scr);
    fld[4]  = OCT_W'(cfg.lanes_m1);
    fld[5]  = cfg.octs_m1;
    fld[6]  = OCT_W'(cfg.frms_m1);
    fld[7]  = cfg.convs_m1;
    fld[8]  = OCT_W'(cfg.ctl_bits);
    fld[9]  = OCT_W'(cfg.res_m1);
    fld[10] = OCT_W'(cfg.smpw_m1);
    fld[11] = OCT_W'(cfg.subcls);
    fld[12] = OCT_W'(cfg.spc_m1);
    fld[13] = OCT_W'(cfg.ver);
    fld[14] = OCT_W'(cfg.ctl_words);
    fld[15] = OCT_W'(cfg.hdens);
  end

  always_comb begin
    fsum = '0;
    for (int i = 0; i < NFLD; i++) begin
      fsum = fsum + fld[i];
    end
  end

  // Packed octets; order is decoded by the receiver
  always_comb begin
    rec[0]  = cfg.dev_id;
    rec[1]  = {4'b0, cfg.bank_id};
    rec[2]  = {3'b0, cfg.lane_id};
    rec[3]  = {cfg.scr, 2'b0, cfg.lanes_m1};
    rec[4]  = cfg.octs_m1;
    rec[5]  = {3'b0, cfg.frms_m1};
    rec[6]  = cfg.convs_m1;
    rec[7]  = {cfg.ctl_bits, 1'b0, cfg.res_m1};
    rec[8]  = {cfg.subcls, cfg.smpw_m1};
    rec[9]  = {cfg.ver, cfg.spc_m1};
    rec[10] = {cfg.hdens, 2'b0, cfg.ctl_words};
    rec[11] = '0;
    rec[12] = '0;
    rec[13] = fsum;
  end

  always_comb begin
    rec_oct = '0;
    for (int i = 0; i < REC_LEN; i++) begin
      if (sel == 4'(i)) rec_oct = rec[i];
    end
  end

endmodule

// File: rtl/ila_octet_timer.sv
module ila_octet_timer
  import lane_ila_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [KF_W-1:0] kf_m1,
  output logic [KF_W-1:0] pos,
  output logic            mf_last
);

  assign mf_last = (pos >= kf_m1);

  always_ff @(posedge clk) begin
    if (rst)          pos <= '0;
    else if (mf_last) pos <= '0;
    else              pos <= pos + KF_W'(1);
  end

endmodule

// File: rtl/lane_ila_seq.sv
module lane_ila_seq
  import lane_ila_pkg::*;
#(
  parameter int ALIGN_MF = 4,
  parameter int CFG_MF   = 1,
  parameter int REC_OFS  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_req,
  input  logic [1:0] seq_mode,
  input  logic       scr_cfg,
  input  logic [7:0] dev_id,
  input  logic [3:0] bank_id,
  input  logic [4:0] lane_id,
  input  logic [4:0] lanes_m1,
  input  logic [7:0] octs_m1,
  input  logic [4:0] frms_m1,
  input  logic [7:0] convs_m1,
  input  logic [4:0] res_m1,
  input  logic [4:0] smpw_m1,
  input  logic [1:0] ctl_bits,
  input  logic [4:0] ctl_words,
  input  logic [4:0] spc_m1,
  input  logic       hdens,
  input  logic [2:0] subcls,
  input  logic [2:0] ver,
  input  logic [7:0] pl_octet,
  output logic [7:0] tx_octet,
  output logic       tx_ctrl,
  output logic       scr_on,
  output logic       cfg_err
);

  localparam int MF_W    = (ALIGN_MF > 1) ? $clog2(ALIGN_MF) : 1;
  localparam int REC_END = REC_OFS + REC_LEN - 1;

  link_cfg_t        cfg_in;
  link_cfg_t        cfg;
  logic [KF_W-1:0]  kf_m1;
  logic             bad_cfg;
  logic [KF_W-1:0]  pos;
  logic             mf_last;
  logic [3:0]       rec_sel;
  logic [OCT_W-1:0] rec_oct;

  seq_state_e       state;
  logic [MF_W-1:0]  mf_idx;

  logic [OCT_W-1:0] nx_octet;
  logic             nx_ctrl;
  logic             nx_scr;

  always_comb begin
    cfg_in.dev_id    = dev_id;
    cfg_in.bank_id   = bank_id;
    cfg_in.lane_id   = lane_id;
    cfg_in.scr       = scr_cfg;
    cfg_in.lanes_m1  = lanes_m1;
    cfg_in.octs_m1   = octs_m1;
    cfg_in.frms_m1   = frms_m1;
    cfg_in.convs_m1  = convs_m1;
    cfg_in.res_m1    = res_m1;
    cfg_in.smpw_m1   = smpw_m1;
    cfg_in.ctl_bits  = ctl_bits;
    cfg_in.ctl_words = ctl_words;
    cfg_in.spc_m1    = spc_m1;
    cfg_in.hdens     = hdens;
    cfg_in.subcls    = subcls;
    cfg_in.ver       = ver;
    cfg_in.mode      = seq_mode_e'(seq_mode);
  end

  ila_cfg_shadow u_shadow (
    .clk    (clk),
    .rst    (rst),
    .load   (sync_req),
    .cfg_in (cfg_in),
    .cfg_q  (cfg)
  );

  ila_cfg_check u_check (
    .cfg   (cfg),
    .kf_m1 (kf_m1),
    .bad   (bad_cfg)
  );

  ila_octet_timer u_timer (
    .clk     (clk),
    .rst     (rst),
    .kf_m1   (kf_m1),
    .pos     (pos),
    .mf_last (mf_last)
  );

  assign rec_sel = 4'(pos - KF_W'(REC_OFS));

  ila_cfg_record u_record (
    .cfg     (cfg),
    .sel     (rec_sel),
    .rec_oct (rec_oct)
  );

  // Sequence control: changes take effect at the multiframe boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_SYNC;
      mf_idx <= '0;
    end else if (sync_req) begin
      state  <= ST_SYNC;
      mf_idx <= '0;
    end else if (mf_last) begin
      case (state)
        ST_SYNC: begin
          mf_idx <= '0;
          state  <= (cfg.mode == MODE_OFF) ? ST_DATA : ST_ALIGN;
        end
        ST_ALIGN: begin
          if (mf_idx == MF_W'(ALIGN_MF - 1)) begin
            mf_idx <= '0;
            if (cfg.mode != MODE_LOOP) state <= ST_DATA;
          end else begin
            mf_idx <= mf_idx + MF_W'(1);
          end
        end
        default: state <= ST_DATA;
      endcase
    end
  end

  // Octet selection for the current position
  always_comb begin
    nx_octet = CH_COMMA;
    nx_ctrl  = 1'b1;
    nx_scr   = 1'b0;
    case (state)
      ST_DATA: begin
        nx_octet = pl_octet;
        nx_ctrl  = 1'b0;
        nx_scr   = cfg.scr;
      end
      ST_ALIGN: begin
        if (pos == '0) begin
          nx_octet = CH_START;
        end else if (mf_last) begin
          nx_octet = CH_ALIGN;
        end else if (mf_idx == MF_W'(CFG_MF) && pos == KF_W'(REC_OFS - 1)) begin
          nx_octet = CH_CFG;
        end else if (mf_idx == MF_W'(CFG_MF) && pos >= KF_W'(REC_OFS) &&
                     pos <= KF_W'(REC_END)) begin
          nx_octet = rec_oct;
          nx_ctrl  = 1'b0;
        end else begin
          nx_octet = pos[OCT_W-1:0];
          nx_ctrl  = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_octet <= CH_COMMA;
      tx_ctrl  <= 1'b1;
      scr_on   <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      tx_octet <= nx_octet;
      tx_ctrl  <= nx_ctrl;
      scr_on   <= nx_scr;
      cfg_err  <= bad_cfg;
    end
  end

endmodule

// File: rtl/lane_ila_seq_chk.sv
module lane_ila_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       sync_req,
  input logic [7:0] tx_octet,
  input logic       tx_ctrl,
  input logic       scr_on,
  input logic       cfg_err
);

  AST_SYNC_SENDS_COMMA: assert property (@(posedge clk) disable iff (rst)
    $past(sync_req, 2) |-> (tx_ctrl && tx_octet == 8'hBC)); // R2

  AST_SCR_NOT_ON_CTRL: assert property (@(posedge clk) disable iff (rst)
    scr_on |-> !tx_ctrl); // R8

  AST_NO_SCR_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
    $past(sync_req, 2) |-> !scr_on); // R8

  AST_CTRL_CODE_SET: assert property (@(posedge clk) disable iff (rst)
    tx_ctrl |-> (tx_octet == 8'hBC || tx_octet == 8'h1C ||
                 tx_octet == 8'h7C || tx_octet == 8'h9C)); // R4

  AST_ERR_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$past(sync_req, 2) |-> $stable(cfg_err)); // R10

endmodule

bind lane_ila_seq lane_ila_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sync_req (sync_req),
  .tx_octet (tx_octet),
  .tx_ctrl  (tx_ctrl),
  .scr_on   (scr_on),
  .cfg_err  (cfg_err)
);

// File: tb/tb_lane_ila_seq.sv
`timescale 1ns/1ps
module tb_lane_ila_seq;

  localparam int CAPN = 600;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_req = 1'b0;
  logic [1:0] seq_mode = 2'b01;
  logic       scr_cfg = 1'b1;
  logic [7:0] dev_id = 8'h5A;
  logic [3:0] bank_id = 4'h3;
  logic [4:0] lane_id = 5'h11;
  logic [4:0] lanes_m1 = 5'd0;
  logic [7:0] octs_m1 = 8'd1;
  logic [4:0] frms_m1 = 5'd15;
  logic [7:0] convs_m1 = 8'd0;
  logic [4:0] res_m1 = 5'd13;
  logic [4:0] smpw_m1 = 5'd15;
  logic [1:0] ctl_bits = 2'd2;
  logic [4:0] ctl_words = 5'd0;
  logic [4:0] spc_m1 = 5'd0;
  logic       hdens = 1'b1;
  logic [2:0] subcls = 3'd1;
  logic [2:0] ver = 3'd1;
  logic [7:0] pl_octet = 8'hE7;
  logic [7:0] tx_octet;
  logic       tx_ctrl;
  logic       scr_on;
  logic       cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] cap_o [CAPN];
  logic       cap_k [CAPN];
  logic       cap_s [CAPN];

  always #10 clk = ~clk;

  lane_ila_seq dut (
    .clk(clk), .rst(rst), .sync_req(sync_req), .seq_mode(seq_mode),
    .scr_cfg(scr_cfg), .dev_id(dev_id), .bank_id(bank_id), .lane_id(lane_id),
    .lanes_m1(lanes_m1), .octs_m1(octs_m1), .frms_m1(frms_m1),
    .convs_m1(convs_m1), .res_m1(res_m1), .smpw_m1(smpw_m1),
    .ctl_bits(ctl_bits), .ctl_words(ctl_words), .spc_m1(spc_m1),
    .hdens(hdens), .subcls(subcls), .ver(ver), .pl_octet(pl_octet),
    .tx_octet(tx_octet), .tx_ctrl(tx_ctrl), .scr_on(scr_on), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sum();
    int s;
    s = dev_id + bank_id + lane_id + scr_cfg + lanes_m1 + octs_m1 + frms_m1 +
        convs_m1 + ctl_bits + res_m1 + smpw_m1 + subcls + spc_m1 + ver +
        ctl_words + hdens;
    return 8'(s);
  endfunction

  function automatic logic [7:0] exp_rec(input int i);
    case (i)
      0:  return dev_id;
      1:  return {4'h0, bank_id};
      2:  return {3'b0, lane_id};
      3:  return {scr_cfg, 2'b0, lanes_m1};
      4:  return octs_m1;
      5:  return {3'b0, frms_m1};
      6:  return convs_m1;
      7:  return {ctl_bits, 1'b0, res_m1};
      8:  return {subcls, smpw_m1};
      9:  return {ver, spc_m1};
      10: return {hdens, 2'b0, ctl_words};
      13: return exp_sum();
      default: return 8'h00;
    endcase
  endfunction

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cap_o[i] = tx_octet;
      cap_k[i] = tx_ctrl;
      cap_s[i] = scr_on;
    end
  endtask

  function automatic int first_non_comma(input int n);
    for (int i = 0; i < n; i++)
      if (!(cap_k[i] && cap_o[i] == 8'hBC)) return i;
    return n;
  endfunction

  task automatic load_and_release(input logic [1:0] mode);
    @(negedge clk);
    seq_mode = mode;
    sync_req = 1'b1;
    repeat (4) @(negedge clk);
    sync_req = 1'b0;
  endtask

  // Checks a stream of pattern multiframes starting at i0
  task automatic check_pattern(input int i0, input int kf, input int nmf, input bit rec_chk);
    for (int m = 0; m < nmf; m++) begin
      int b;
      b = i0 + m * kf;
      chk(cap_k[b] && cap_o[b] == 8'h1C, "R3 start char", cap_o[b], 8'h1C);
      chk(cap_k[b+kf-1] && cap_o[b+kf-1] == 8'h7C, "R3 end char", cap_o[b+kf-1], 8'h7C);
      chk(!cap_k[b+kf-2] && cap_o[b+kf-2] == 8'(kf-2), "R4 ramp filler",
          cap_o[b+kf-2], kf-2);
      for (int j = 0; j < kf; j++)
        if (cap_s[b+j]) chk(0, "R8 scr_on during pattern", 1, 0);
      if ((m % 4) == 1) begin
        chk(cap_k[b+1] && cap_o[b+1] == 8'h9C, "R4 record marker", cap_o[b+1], 8'h9C);
        if (rec_chk) begin
          for (int r = 0; r < 13; r++)
            chk(!cap_k[b+2+r] && cap_o[b+2+r] == exp_rec(r), "R5 record octet",
                cap_o[b+2+r], exp_rec(r));
          chk(!cap_k[b+15] && cap_o[b+15] == exp_sum(), "R6 checksum",
              cap_o[b+15], exp_sum());
        end
      end else begin
        chk(!cap_k[b+1] && cap_o[b+1] == 8'd1, "R4 ramp at octet 1", cap_o[b+1], 1);
      end
    end
  endtask

  task automatic t_reset_defaults();
    rst = 1'b1;
    sync_req = 1'b0;
    frms_m1 = 5'd7;     // live input differs from the default K
    octs_m1 = 8'd0;
    seq_mode = 2'b00;   // live input differs from the default mode
    repeat (3) @(negedge clk);
    chk(tx_octet == 8'hBC && tx_ctrl, "R1 reset comma", tx_octet, 8'hBC);
    chk(!scr_on, "R1 reset scr_on", scr_on, 0);
    chk(!cfg_err, "R1 reset cfg_err", cfg_err, 0);
    rst = 1'b0;
    capture(120);
    begin
      int i0;
      i0 = first_non_comma(120);
      chk(i0 <= 35, "R1 default start", i0, 32);
      chk(cap_k[i0] && cap_o[i0] == 8'h1C, "R1 default mode plays pattern", cap_o[i0], 8'h1C);
      chk(cap_k[i0+31] && cap_o[i0+31] == 8'h7C, "R1 default K=32 end", cap_o[i0+31], 8'h7C);
      chk(cap_k[i0+32] && cap_o[i0+32] == 8'h1C, "R1 default K=32 next start",
          cap_o[i0+32], 8'h1C);
    end
  endtask

  task automatic t_once(input logic scr_sel);
    int i0;
    frms_m1 = 5'd15; octs_m1 = 8'd1; scr_cfg = scr_sel;
    load_and_release(2'b01);
    capture(200);
    i0 = first_non_comma(200);
    chk(i0 <= 35, "R3 start at boundary", i0, 32);
    check_pattern(i0, 32, 4, 1'b1);
    chk(!cap_k[i0+128] && cap_o[i0+128] == 8'hE7, "R9 payload", cap_o[i0+128], 8'hE7);
    chk(cap_s[i0+128] == scr_sel, "R8 scr_on on payload", cap_s[i0+128], scr_sel);
    chk(!cap_k[i0+150] && cap_o[i0+150] == 8'hE7, "R7 once stays in payload",
        cap_o[i0+150], 8'hE7);
  endtask

  task automatic t_mode_off();
    int i0;
    scr_cfg = 1'b1;
    load_and_release(2'b00);
    capture(60);
    i0 = first_non_comma(60);
    chk(i0 <= 35, "R7 off mode start", i0, 32);
    chk(!cap_k[i0] && cap_o[i0] == 8'hE7, "R7 off mode payload first", cap_o[i0], 8'hE7);
    chk(cap_s[i0], "R8 off mode scr_on", cap_s[i0], 1);
  endtask

  task automatic t_repeat();
    int i0;
    load_and_release(2'b10);
    capture(320);
    i0 = first_non_comma(320);
    chk(i0 <= 35, "R7 repeat start", i0, 32);
    check_pattern(i0, 32, 8, 1'b1);
  endtask

  task automatic t_abort();
    load_and_release(2'b01);
    while (!(tx_ctrl && tx_octet == 8'h1C)) @(negedge clk);
    repeat (10) @(negedge clk);
    sync_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_ctrl && tx_octet == 8'hBC, "R2 abort to comma", tx_octet, 8'hBC);
    @(negedge clk);
    chk(tx_ctrl && tx_octet == 8'hBC, "R2 comma held", tx_octet, 8'hBC);
    sync_req = 1'b0;
  endtask

  task automatic t_cfg_err(input logic [4:0] k_m1, input logic [7:0] f_m1, input bit exp_err);
    @(negedge clk);
    sync_req = 1'b1;
    frms_m1 = k_m1;
    octs_m1 = f_m1;
    repeat (3) @(negedge clk);
    chk(cfg_err == exp_err, "R10 config check", cfg_err, exp_err);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_defaults();
    t_once(1'b1);
    t_once(1'b0);
    t_mode_off();
    t_repeat();
    t_abort();
    t_cfg_err(5'd5,  8'd3,  1'b1);  // K=6 not multiple of 4
    t_cfg_err(5'd7,  8'd0,  1'b1);  // K*F = 8 < 17
    t_cfg_err(5'd31, 8'd63, 1'b1);  // K*F = 2048 > 1024
    t_cfg_err(5'd31, 8'd31, 1'b0);  // K*F = 1024
    t_cfg_err(5'd19, 8'd0,  1'b0);  // K*F = 20
    t_cfg_err(5'd15, 8'd1,  1'b0);  // K*F = 32
    sync_req = 1'b0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule